// File: doc/BRIEF.md
# Vertical-Blank Framebuffer Flip Controller

This block arbitrates ownership of two framebuffers shared by a renderer and a display scanner that run on unrelated clocks. At any moment one buffer is the back buffer (the renderer draws into it) and the other is the front buffer (the display scans it out). The renderer reports a finished frame with a one-cycle pulse and is then stalled. The two buffers trade roles only when two conditions hold together: a finished frame is waiting, and the display is inside its vertical blanking interval. The display therefore never shows a partly drawn frame, and the renderer does not have to keep pace with the scan.

The handshake crosses the clock boundary as a pair of toggle signals, one in each direction, each through a chain of synchronizer flops. The request toggle flips when a frame finishes. The acknowledge toggle flips when the display side has performed the exchange. The render side releases the renderer and flips its own back-buffer index once the acknowledge arrives. Each side has its own asynchronous active-low reset.

Top module: `fb_flip_ctrl`

## Requirements
- R1: After reset the renderer is ready (`rnd_ready`=1), draws into buffer 0 (`rnd_back_sel`=0), and the display shows buffer 1 (`dsp_front_sel`=1).
- R2: A `rnd_frame_done` pulse while `rnd_ready` is 1 drives `rnd_ready` to 0 on the next render clock edge. `rnd_ready` stays 0 until the exchange for that frame has been acknowledged.
- R3: A `rnd_frame_done` pulse while `rnd_ready` is 0 is ignored and causes no extra exchange.
- R4: `dsp_front_sel` changes only on a display clock edge where `dsp_vblank` is 1 and a finished frame is waiting. A finished frame never reaches the display outside vertical blanking.
- R5: A vertical blanking interval with no finished frame waiting leaves `dsp_front_sel` unchanged.
- R6: At most one exchange happens per vertical blanking interval. A frame finished during an interval that has already had an exchange waits for the next interval.
- R7: When the renderer is released, `rnd_back_sel` has flipped and now names the buffer the display is not showing. `rnd_back_sel` changes only on the edge where `rnd_ready` rises.
- R8: Request and acknowledge events cross clock domains as toggles through `SYNC_STAGES` flops (at least 2). An exchange completes for any vertical blanking length of one display cycle or more, once the request has had time to cross.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rnd_clk | input | 1 | Render-domain clock |
| rnd_rst_n | input | 1 | Render-domain asynchronous reset, active low |
| rnd_frame_done | input | 1 | One-cycle pulse: the back buffer holds a finished frame |
| rnd_ready | output | 1 | Renderer may draw into the back buffer |
| rnd_back_sel | output | 1 | Index of the buffer the renderer draws into |
| dsp_clk | input | 1 | Display-domain clock |
| dsp_rst_n | input | 1 | Display-domain asynchronous reset, active low |
| dsp_vblank | input | 1 | Display is in vertical blanking |
| dsp_front_sel | output | 1 | Index of the buffer the display scans out |

## Verification
The checker assumes three things about the inputs. `rnd_frame_done` is synchronous to the render clock. `dsp_vblank` is a registered level synchronous to the display clock. Both resets are asserted together from time zero. The bench drives each input on the falling edge of its own clock. Before any short blanking interval in the sweep, the bench waits long enough for the request toggle to cross. Under these conditions every swap the bench expects is fully determined by the order of events, and the bench does not need to know the exact latency across the clock boundary.

// File: rtl/fb_flip_pkg.sv
package fb_flip_pkg;
   typedef logic buf_id_t;
   localparam buf_id_t RESET_BACK  = 1'b0;
   localparam buf_id_t RESET_FRONT = 1'b1;
   typedef enum logic {RS_DRAW = 1'b0, RS_WAIT = 1'b1} rnd_state_t;
endpackage

// File: rtl/fb_flip_tsync.sv
module fb_flip_tsync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgl_in,
   output logic tgl_out
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad
         $error("fb_flip_tsync: STAGES must be at least 2");
      end
   endgenerate

   logic [LAST:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= tgl_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign tgl_out = chain[LAST];
endmodule

// File: rtl/fb_flip_rnd_side.sv
module fb_flip_rnd_side
   import fb_flip_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    frame_done,
   input  logic    ack_sync,
   output logic    req_tgl,
   output logic    ready,
   output buf_id_t back_sel
);
   rnd_state_t state;
   logic       ack_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RS_DRAW;
         req_tgl  <= 1'b0;
         ack_seen <= 1'b0;
         back_sel <= RESET_BACK;
      end else begin
         unique case (state)
            RS_DRAW: begin
               if (frame_done) begin
                  req_tgl <= ~req_tgl;
                  state   <= RS_WAIT;
               end
            end
            RS_WAIT: begin
               if (ack_sync != ack_seen) begin
                  ack_seen <= ack_sync;
                  back_sel <= ~back_sel;
                  state    <= RS_DRAW;
               end
            end
            default: state <= RS_DRAW;
         endcase
      end
   end

   assign ready = (state == RS_DRAW);
endmodule

// File: rtl/fb_flip_dsp_side.sv
module fb_flip_dsp_side
   import fb_flip_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    vblank,
   input  logic    req_sync,
   output logic    ack_tgl,
   output buf_id_t front_sel
);
   logic req_seen;
   logic used_this_vb;
   logic pending;

   assign pending = req_sync ^ req_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         front_sel    <= RESET_FRONT;
         req_seen     <= 1'b0;
         ack_tgl      <= 1'b0;
         used_this_vb <= 1'b0;
      end else if (!vblank) begin
         used_this_vb <= 1'b0;
      end else if (pending && !used_this_vb) begin
         front_sel    <= ~front_sel;
         req_seen     <= req_sync;
         ack_tgl      <= ~ack_tgl;
         used_this_vb <= 1'b1;
      end
   end
endmodule

// File: rtl/fb_flip_ctrl.sv
module fb_flip_ctrl #(
   parameter int SYNC_STAGES = 2
) (
   input  logic rnd_clk,
   input  logic rnd_rst_n,
   input  logic rnd_frame_done,
   output logic rnd_ready,
   output logic rnd_back_sel,
   input  logic dsp_clk,
   input  logic dsp_rst_n,
   input  logic dsp_vblank,
   output logic dsp_front_sel
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad
         $error("fb_flip_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic req_tgl, req_sync;
   logic ack_tgl, ack_sync;

   fb_flip_rnd_side u_rnd (
      .clk(rnd_clk), .rst_n(rnd_rst_n), .frame_done(rnd_frame_done),
      .ack_sync(ack_sync), .req_tgl(req_tgl), .ready(rnd_ready),
      .back_sel(rnd_back_sel)
   );

   fb_flip_tsync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(dsp_clk), .rst_n(dsp_rst_n), .tgl_in(req_tgl), .tgl_out(req_sync)
   );

   fb_flip_dsp_side u_dsp (
      .clk(dsp_clk), .rst_n(dsp_rst_n), .vblank(dsp_vblank),
      .req_sync(req_sync), .ack_tgl(ack_tgl), .front_sel(dsp_front_sel)
   );

   fb_flip_tsync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(rnd_clk), .rst_n(rnd_rst_n), .tgl_in(ack_tgl), .tgl_out(ack_sync)
   );
endmodule

// File: rtl/fb_flip_ctrl_chk.sv
module fb_flip_ctrl_chk (
   input logic rnd_clk,
   input logic rnd_rst_n,
   input logic rnd_frame_done,
   input logic rnd_ready,
   input logic rnd_back_sel,
   input logic dsp_clk,
   input logic dsp_rst_n,
   input logic dsp_vblank,
   input logic dsp_front_sel
);
   AST_READY_DROPS: assert property (@(posedge rnd_clk) disable iff (!rnd_rst_n)
      (rnd_ready && rnd_frame_done) |=> !rnd_ready); // R2

   AST_BACK_ON_RELEASE: assert property (@(posedge rnd_clk) disable iff (!rnd_rst_n)
      !$stable(rnd_back_sel) |-> (rnd_ready && !$past(rnd_ready))); // R7

   AST_FRONT_IN_VBLANK: assert property (@(posedge dsp_clk) disable iff (!dsp_rst_n)
      !$stable(dsp_front_sel) |-> $past(dsp_vblank)); // R4

   AST_NO_BACK_TO_BACK: assert property (@(posedge dsp_clk) disable iff (!dsp_rst_n)
      !$stable(dsp_front_sel) |=> $stable(dsp_front_sel)); // R6
endmodule

bind fb_flip_ctrl fb_flip_ctrl_chk u_chk (.*);

// File: tb/fb_flip_ctrl_bench.sv
module fb_flip_ctrl_bench;
   logic rclk = 1'b0, dclk = 1'b0;
   logic rrst_n = 1'b0, drst_n = 1'b0;
   logic done = 1'b0, vb = 1'b0;
   logic ready, back, front;

   int checks = 0, errors = 0;
   int swaps = 0;
   logic front_prev = 1'b1;
   logic exp_front = 1'b1;
   int exp_swaps = 0;

   always #2 rclk = ~rclk;
   always #3.5 dclk = ~dclk;

   fb_flip_ctrl u_fb_flip_ctrl (
      .rnd_clk(rclk), .rnd_rst_n(rrst_n), .rnd_frame_done(done),
      .rnd_ready(ready), .rnd_back_sel(back),
      .dsp_clk(dclk), .dsp_rst_n(drst_n), .dsp_vblank(vb),
      .dsp_front_sel(front)
   );

   always @(negedge dclk) begin
      if (drst_n) begin
         if (front !== front_prev) swaps++;
         front_prev = front;
      end
   end

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic rwait(input int n);
      for (int i = 0; i < n; i++) @(negedge rclk);
   endtask

   task automatic dwait(input int n);
      for (int i = 0; i < n; i++) @(negedge dclk);
   endtask

   task automatic pulse_done();
      @(negedge rclk) done = 1'b1;
      @(negedge rclk) done = 1'b0;
   endtask

   task automatic vblank_for(input int n);
      @(negedge dclk) vb = 1'b1;
      dwait(n);
      vb = 1'b0;
   endtask

   task automatic wait_ready(input string tag);
      int t = 0;
      while (!ready && t < 60) begin
         @(negedge rclk);
         t++;
      end
      chk(ready === 1'b1, tag, int'(ready), 1);
   endtask

   task automatic check_swap(input string tag);
      exp_front = ~exp_front;
      exp_swaps++;
      dwait(1);
      chk(front === exp_front, {tag, " front"}, int'(front), int'(exp_front));
      chk(back === ~exp_front, {tag, " back"}, int'(back), int'(~exp_front));
      chk(swaps == exp_swaps, {tag, " swap count"}, swaps, exp_swaps);
   endtask

   initial begin
      #40000;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rwait(5);
      rrst_n = 1'b1;
      drst_n = 1'b1;
      rwait(2);
      // R1 reset state
      chk(ready === 1'b1, "R1 ready", int'(ready), 1);
      chk(back === 1'b0, "R1 back", int'(back), 0);
      chk(front === 1'b1, "R1 front", int'(front), 1);

      // R5: blanking with no frame waiting
      vblank_for(6);
      dwait(4);
      chk(front === 1'b1 && swaps == 0, "R5 no frame", swaps, 0);

      // R2 hold, R4 no vblank means no swap, R3 ignored extra pulse
      pulse_done();
      chk(ready === 1'b0, "R2 ready drops", int'(ready), 0);
      rwait(25);
      chk(ready === 1'b0, "R2 held", int'(ready), 0);
      chk(swaps == 0, "R4 no swap outside vblank", swaps, 0);
      pulse_done();
      vblank_for(8);
      wait_ready("R7 release");
      check_swap("R7 first");
      vblank_for(8);
      dwait(4);
      chk(swaps == exp_swaps, "R3 ignored pulse", swaps, exp_swaps);

      // R8 sweep of blanking length after request has crossed
      for (int len = 1; len <= 6; len++) begin
         pulse_done();
         dwait(12);
         chk(swaps == exp_swaps, "R4 waits for vblank", swaps, exp_swaps);
         vblank_for(len);
         wait_ready("R8 release");
         check_swap("R8 sweep");
      end

      // R6: second frame within the same blanking interval waits
      @(negedge dclk) vb = 1'b1;
      pulse_done();
      wait_ready("R6 first release");
      check_swap("R6 first");
      pulse_done();
      dwait(30);
      chk(swaps == exp_swaps, "R6 one swap per vblank", swaps, exp_swaps);
      chk(ready === 1'b0, "R6 renderer held", int'(ready), 0);
      vb = 1'b0;
      dwait(3);
      vblank_for(6);
      wait_ready("R6 second release");
      check_swap("R6 next vblank");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule